// File: doc/BRIEF.md
# Gated Complementary Half-Bridge Gate Driver Chain

This block sits between a bank of per-lane modulators and the gate drivers of a set of half-bridges. Every clock it takes one request bit per lane (plus a second request bit used only in the independent mode). It turns each lane into a high-side and a low-side gate signal. In the complementary mode the two sides are driven opposite to each other, and a programmable number of all-off clock cycles is inserted on every change of the request. Other modes drive the two sides from separate requests, drive the high side alone, or hold the lane off.

Three gates sit above the per-lane logic. The first is a system state machine with three states: `SYS_CFG` (start-up configuration), `SYS_RUN` (normal operation) and `SYS_TRIP` (latched fault block). Its transitions are CFG_TO_RUN on the configuration-done pulse, RUN_TO_TRIP on a high fault input, and TRIP_TO_RUN on a clear request while the fault input is low. The second is a per-lane activation flag, set and cleared by software strobes. The third is the lane's output mode. Each lane's complementary path has its own state machine with three states: `LN_DEAD` (both sides off, counting), `LN_HI` and `LN_LO`. Its transitions are HI_TO_DEAD and LO_TO_DEAD on a request edge when the dead-time is non-zero, and HI_TO_LO and LO_TO_HI on a request edge when the dead-time is zero. DEAD_RESTART fires on a request edge while counting. DEAD_TO_SIDE fires once the count reaches the dead-time. ANY_TO_DEAD fires whenever the lane is not enabled or not in the complementary mode. Mode and dead-time are loaded through a single-cycle write port that addresses one lane at a time.

Top module: `pwm_gate_chain`

## Requirements
- R1: After reset the block is in the configuration state. Until a one-cycle `cfg_done` pulse is seen, every gate output is 0 and activation strobes are ignored. Mode and dead-time writes are accepted.
- R2: Lane n is driven only by bit n of `req_a`, `req_b`, `act_set`, `act_clr` and by the writes addressed to lane n. Inactive lanes drive 0 on both sides.
- R3: In mode 0 (complementary), an enabled lane in steady state drives `gate_hi` equal to its request and `gate_lo` equal to its inverse. Both sides are never 1 in the same cycle.
- R4: In mode 0, on each change of the request the lane drives both sides 0 for exactly the lane's dead-time in clock cycles, then turns on the newly requested side. A dead-time of 0 switches sides in the same cycle.
- R5: In mode 0, a request that changes again before its dead-time has elapsed restarts the count. The side it would have turned on never turns on, and neither output glitches.
- R6: Mode encoding in `wr_data[1:0]`: 0 = complementary, 1 = independent (`gate_hi` follows `req_a`, `gate_lo` follows `req_b`, one cycle later), 2 = high side only (`gate_hi` follows `req_a`, `gate_lo` = 0), 3 = both sides 0.
- R7: In the run state, `act_set[n]` activates lane n and `act_clr[n]` deactivates it; clear wins over set in the same cycle. A deactivated lane drives both sides 0 from the cycle after the clear.
- R8: A high `fault_in` in the run state moves the block to the tripped state (`tripped` = 1) on the next edge. All outputs are then 0 and every lane is deactivated. The trip is held until `fault_clr` is seen while `fault_in` is low, and clearing does not reactivate any lane.
- R9: A write with `wr_en` = 1 loads lane `wr_lane`: `wr_sel` = 0 loads the mode from `wr_data[1:0]`, `wr_sel` = 1 loads the dead-time (cycles) from `wr_data`. After reset the mode is 0 and the dead-time is 8.
- R10: When a mode-0 lane becomes enabled, both sides stay 0 for its dead-time before the requested side turns on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_done | input | 1 | One-cycle pulse marking the end of start-up configuration |
| fault_in | input | 1 | Fault indication, high = fault present |
| fault_clr | input | 1 | Request to leave the tripped state |
| req_a | input | LANES (32) | Per-lane primary modulator request |
| req_b | input | LANES (32) | Per-lane low-side request for the independent mode |
| act_set | input | LANES (32) | Per-lane activation strobe |
| act_clr | input | LANES (32) | Per-lane deactivation strobe |
| wr_en | input | 1 | Write strobe for the lane settings |
| wr_sel | input | 1 | 0 = mode, 1 = dead-time |
| wr_lane | input | $clog2(LANES) (5) | Lane addressed by the write |
| wr_data | input | DT_W (10) | Write data |
| gate_hi | output | LANES (32) | High-side gate signals |
| gate_lo | output | LANES (32) | Low-side gate signals |
| tripped | output | 1 | 1 while the fault block is latched |

## Verification
The complementary path is first driven with isolated single edges on lanes with dead-times 3, 0 and 5. This measures the exact all-off gap and separates a counting error from a missing dead band. A glitch pulse shorter than the dead-time is then applied to show that the count restarts and the opposite side never fires. Random multi-lane request patterns across lanes in different modes expose any crosstalk between lanes or mode mix-ups. Simultaneous set and clear strobes, and fault clears attempted while the fault is still high, separate the priority rules from the plain set and clear behaviour.

// File: rtl/pwm_chain_pkg.sv
package pwm_chain_pkg;

    typedef enum logic [1:0] {
        SYS_CFG  = 2'd0,
        SYS_RUN  = 2'd1,
        SYS_TRIP = 2'd2
    } sys_st_t;

    typedef enum logic [1:0] {
        LN_DEAD = 2'd0,
        LN_HI   = 2'd1,
        LN_LO   = 2'd2
    } lane_st_t;

    typedef enum logic [1:0] {
        MD_COMP   = 2'd0,
        MD_INDEP  = 2'd1,
        MD_HIONLY = 2'd2,
        MD_OFF    = 2'd3
    } lane_mode_t;

endpackage

// File: rtl/pwm_sys_fsm.sv
module pwm_sys_fsm
    import pwm_chain_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_done,
    input  logic fault_in,
    input  logic fault_clr,
    output logic run,
    output logic kill,
    output logic in_cfg,
    output logic tripped
);

    sys_st_t st_q, st_d;

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            SYS_CFG:  if (cfg_done)               st_d = SYS_RUN;   // CFG_TO_RUN
            SYS_RUN:  if (fault_in)               st_d = SYS_TRIP;  // RUN_TO_TRIP
            SYS_TRIP: if (fault_clr && !fault_in) st_d = SYS_RUN;   // TRIP_TO_RUN
            default:                              st_d = SYS_CFG;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= SYS_CFG;
        else        st_q <= st_d;
    end

    // outputs
    always_comb begin
        run     = (st_q == SYS_RUN);
        in_cfg  = (st_q == SYS_CFG);
        tripped = (st_q == SYS_TRIP);
        kill    = (st_q == SYS_RUN) && fault_in;
    end

endmodule

// File: rtl/pwm_lane.sv
module pwm_lane
    import pwm_chain_pkg::*;
#(
    parameter int DT_W   = 10,
    parameter int DT_RST = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic            kill,
    input  logic            req_a,
    input  logic            req_b,
    input  logic            act_set,
    input  logic            act_clr,
    input  logic            wr_mode,
    input  logic            wr_dt,
    input  logic [DT_W-1:0] wr_data,
    output logic            gate_hi,
    output logic            gate_lo,
    output logic            act_o,
    output logic            cmp_o
);

    localparam logic [DT_W-1:0] CNT_ONE = DT_W'(1);
    localparam logic [DT_W-1:0] DT_INIT = DT_W'(DT_RST);

    lane_st_t   st_q, st_d;
    lane_mode_t mode_q;
    logic [DT_W-1:0] dt_q, cnt_q, cnt_d;
    logic act_q, reqa_q, reqb_q;
    logic en, held, req_edge;

    assign en       = act_q && run;
    assign held     = !en || (mode_q != MD_COMP);
    assign req_edge = (req_a != reqa_q);

    // settings and activation
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= MD_COMP;
            dt_q   <= DT_INIT;
            act_q  <= 1'b0;
        end else begin
            if (wr_mode) mode_q <= lane_mode_t'(wr_data[1:0]);
            if (wr_dt)   dt_q   <= wr_data;
            if (kill)     act_q <= 1'b0;
            else if (run) act_q <= (act_q || act_set) && !act_clr;
        end
    end

    // next-state logic of the dead-band machine
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        if (held) begin
            st_d  = LN_DEAD;                                   // ANY_TO_DEAD
            cnt_d = CNT_ONE;
        end else begin
            unique case (st_q)
                LN_HI: if (!req_a) begin
                    if (dt_q == '0) st_d = LN_LO;              // HI_TO_LO
                    else begin
                        st_d  = LN_DEAD;                       // HI_TO_DEAD
                        cnt_d = CNT_ONE;
                    end
                end
                LN_LO: if (req_a) begin
                    if (dt_q == '0) st_d = LN_HI;              // LO_TO_HI
                    else begin
                        st_d  = LN_DEAD;                       // LO_TO_DEAD
                        cnt_d = CNT_ONE;
                    end
                end
                LN_DEAD: begin
                    if (req_edge)           cnt_d = CNT_ONE;   // DEAD_RESTART
                    else if (cnt_q >= dt_q) st_d  = req_a ? LN_HI : LN_LO; // DEAD_TO_SIDE
                    else                    cnt_d = cnt_q + CNT_ONE;
                end
                default: begin
                    st_d  = LN_DEAD;
                    cnt_d = CNT_ONE;
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= LN_DEAD;
            cnt_q  <= CNT_ONE;
            reqa_q <= 1'b0;
            reqb_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            cnt_q  <= cnt_d;
            reqa_q <= req_a;
            reqb_q <= req_b;
        end
    end

    // outputs
    always_comb begin
        gate_hi = 1'b0;
        gate_lo = 1'b0;
        if (en) begin
            unique case (mode_q)
                MD_COMP: begin
                    gate_hi = (st_q == LN_HI);
                    gate_lo = (st_q == LN_LO);
                end
                MD_INDEP: begin
                    gate_hi = reqa_q;
                    gate_lo = reqb_q;
                end
                MD_HIONLY: gate_hi = reqa_q;
                MD_OFF: ;
                default: ;
            endcase
        end
    end

    assign act_o = act_q;
    assign cmp_o = (mode_q == MD_COMP);

endmodule

// File: rtl/pwm_gate_chain.sv
module pwm_gate_chain
    import pwm_chain_pkg::*;
#(
    parameter int LANES  = 32,
    parameter int DT_W   = 10,
    parameter int DT_RST = 8,
    localparam int LANE_W = $clog2(LANES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_done,
    input  logic              fault_in,
    input  logic              fault_clr,
    input  logic [LANES-1:0]  req_a,
    input  logic [LANES-1:0]  req_b,
    input  logic [LANES-1:0]  act_set,
    input  logic [LANES-1:0]  act_clr,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [LANE_W-1:0] wr_lane,
    input  logic [DT_W-1:0]   wr_data,
    output logic [LANES-1:0]  gate_hi,
    output logic [LANES-1:0]  gate_lo,
    output logic              tripped
);

    logic sys_run, sys_kill, sys_cfg;
    logic [LANES-1:0] lane_act_v, lane_cmp_v;

    pwm_sys_fsm u_sys (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_done (cfg_done),
        .fault_in (fault_in),
        .fault_clr(fault_clr),
        .run      (sys_run),
        .kill     (sys_kill),
        .in_cfg   (sys_cfg),
        .tripped  (tripped)
    );

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic sel_hit;
        assign sel_hit = wr_en && (wr_lane == LANE_W'(i));

        pwm_lane #(
            .DT_W  (DT_W),
            .DT_RST(DT_RST)
        ) u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .run     (sys_run),
            .kill    (sys_kill),
            .req_a   (req_a[i]),
            .req_b   (req_b[i]),
            .act_set (act_set[i]),
            .act_clr (act_clr[i]),
            .wr_mode (sel_hit && !wr_sel),
            .wr_dt   (sel_hit && wr_sel),
            .wr_data (wr_data),
            .gate_hi (gate_hi[i]),
            .gate_lo (gate_lo[i]),
            .act_o   (lane_act_v[i]),
            .cmp_o   (lane_cmp_v[i])
        );
    end

endmodule

// File: rtl/pwm_gate_chain_chk.sv
module pwm_gate_chain_chk #(
    parameter int LANES = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             fault_in,
    input logic             fault_clr,
    input logic             sys_run,
    input logic             sys_cfg,
    input logic             tripped,
    input logic [LANES-1:0] gate_hi,
    input logic [LANES-1:0] gate_lo,
    input logic [LANES-1:0] lane_act,
    input logic [LANES-1:0] lane_cmp
);

    AST_CFG_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        sys_cfg |-> (gate_hi == '0 && gate_lo == '0)); // R1

    AST_NO_SHOOT_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_hi & gate_lo & lane_cmp) == '0); // R3

    AST_INACTIVE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        ((gate_hi | gate_lo) & ~lane_act) == '0); // R7

    AST_FAULT_TRIPS: assert property (@(posedge clk) disable iff (!rst_n)
        (sys_run && fault_in) |=> tripped); // R8

    AST_TRIP_OUTPUTS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        tripped |-> (gate_hi == '0 && gate_lo == '0 && lane_act == '0)); // R8

    AST_TRIP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (tripped && (!fault_clr || fault_in)) |=> tripped); // R8

endmodule

bind pwm_gate_chain pwm_gate_chain_chk #(.LANES(LANES)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .fault_in (fault_in),
    .fault_clr(fault_clr),
    .sys_run  (sys_run),
    .sys_cfg  (sys_cfg),
    .tripped  (tripped),
    .gate_hi  (gate_hi),
    .gate_lo  (gate_lo),
    .lane_act (lane_act_v),
    .lane_cmp (lane_cmp_v)
);

// File: tb/pwm_gate_chain_tb.sv
`timescale 1ns/1ps
module pwm_gate_chain_tb;

    localparam int LANES = 32;
    localparam int DT_W  = 10;
    localparam int LW    = $clog2(LANES);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_done = 0, fault_in = 0, fault_clr = 0;
    logic [LANES-1:0] req_a = '0, req_b = '0, act_set = '0, act_clr = '0;
    logic wr_en = 0, wr_sel = 0;
    logic [LW-1:0] wr_lane = '0;
    logic [DT_W-1:0] wr_data = '0;
    logic [LANES-1:0] gate_hi, gate_lo;
    logic tripped;

    int checks = 0, errors = 0, cycles = 0;
    string cur_tag = "R1";

    always #4 clk = ~clk;

    pwm_gate_chain #(.LANES(LANES), .DT_W(DT_W), .DT_RST(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_done(cfg_done), .fault_in(fault_in),
        .fault_clr(fault_clr), .req_a(req_a), .req_b(req_b), .act_set(act_set),
        .act_clr(act_clr), .wr_en(wr_en), .wr_sel(wr_sel), .wr_lane(wr_lane),
        .wr_data(wr_data), .gate_hi(gate_hi), .gate_lo(gate_lo), .tripped(tripped)
    );

    // behavioural reference model
    int m_mode[LANES], m_dt[LANES], m_st[LANES], m_cnt[LANES];
    bit m_act[LANES], m_ra[LANES], m_rb[LANES];
    int m_sys; // 0 cfg, 1 run, 2 trip
    logic [LANES-1:0] e_hi, e_lo;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_sys = 0;
            for (int i = 0; i < LANES; i++) begin
                m_mode[i] = 0; m_dt[i] = 8; m_st[i] = 0; m_cnt[i] = 1;
                m_act[i] = 0; m_ra[i] = 0; m_rb[i] = 0;
            end
        end else begin
            bit kill;
            kill = (m_sys == 1) && fault_in;
            for (int i = 0; i < LANES; i++) begin
                bit en;
                en = m_act[i] && (m_sys == 1);
                if (!en || m_mode[i] != 0) begin
                    m_st[i] = 0; m_cnt[i] = 1;
                end else if (m_st[i] == 1) begin
                    if (!req_a[i]) begin
                        if (m_dt[i] == 0) m_st[i] = 2; else begin m_st[i] = 0; m_cnt[i] = 1; end
                    end
                end else if (m_st[i] == 2) begin
                    if (req_a[i]) begin
                        if (m_dt[i] == 0) m_st[i] = 1; else begin m_st[i] = 0; m_cnt[i] = 1; end
                    end
                end else begin
                    if (req_a[i] != m_ra[i]) m_cnt[i] = 1;
                    else if (m_cnt[i] >= m_dt[i]) m_st[i] = req_a[i] ? 1 : 2;
                    else m_cnt[i] = m_cnt[i] + 1;
                end
                m_ra[i] = req_a[i];
                m_rb[i] = req_b[i];
                if (kill) m_act[i] = 0;
                else if (m_sys == 1) m_act[i] = (m_act[i] | act_set[i]) & ~act_clr[i];
                if (wr_en && wr_lane == LW'(i)) begin
                    if (wr_sel) m_dt[i] = int'(wr_data);
                    else        m_mode[i] = int'(wr_data[1:0]);
                end
            end
            case (m_sys)
                0: if (cfg_done) m_sys = 1;
                1: if (fault_in) m_sys = 2;
                default: if (fault_clr && !fault_in) m_sys = 1;
            endcase
        end
        for (int i = 0; i < LANES; i++) begin
            bit en;
            en = m_act[i] && (m_sys == 1);
            e_hi[i] = 0; e_lo[i] = 0;
            if (en) begin
                case (m_mode[i])
                    0: begin e_hi[i] = (m_st[i] == 1); e_lo[i] = (m_st[i] == 2); end
                    1: begin e_hi[i] = m_ra[i]; e_lo[i] = m_rb[i]; end
                    2: e_hi[i] = m_ra[i];
                    default: ;
                endcase
            end
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            checks++;
            if (gate_hi !== e_hi || gate_lo !== e_lo || tripped !== (m_sys == 2)) begin
                errors++;
                $display("FAIL %s model: hi=%h lo=%h trip=%b expected hi=%h lo=%h trip=%b",
                         cur_tag, gate_hi, gate_lo, tripped, e_hi, e_lo, (m_sys == 2));
            end
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input int lane, input bit sel, input int data);
        wr_en = 1; wr_sel = sel; wr_lane = LW'(lane); wr_data = DT_W'(data);
        step(1);
        wr_en = 0;
    endtask

    task automatic gap_lo_to_hi(input int lane, output int n);
        n = 0;
        req_a[lane] = 1'b1;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (gate_hi[lane]) break;
            if (!gate_lo[lane]) n++;
        end
    endtask

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++;
            $display("FAIL watchdog: actual=%0d expected<=20000 cycles", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int n;
        bit seen;
        step(3);
        rst_n = 1;
        step(1);
        cur_tag = "R1";
        chk("R1 reset outputs", {gate_hi, gate_lo}, 64'h0);
        chk("R1 reset trip", {63'h0, tripped}, 64'h0);
        act_set = '1; req_a = '1; req_b = '1;
        step(3);
        chk("R1 config hold", {gate_hi, gate_lo}, 64'h0);
        act_set = '0; req_a = '0; req_b = '0;

        // R9 writes during configuration
        cur_tag = "R9";
        wr(0, 1, 3); wr(1, 1, 0); wr(2, 1, 5);
        wr(3, 0, 1); wr(4, 0, 2); wr(5, 0, 3);
        cfg_done = 1; step(1); cfg_done = 0;
        step(1);
        chk("R1 strobes in config ignored", {gate_hi, gate_lo}, 64'h0);

        // R7 / R10 activation
        cur_tag = "R10";
        act_set = 32'h7F; step(1); act_set = '0;
        chk("R10 no side right after enable", {32'h0, gate_lo & 32'h7}, 64'h0);
        step(12);
        chk("R10 low side after dead-time", {59'h0, gate_lo[4:0] & 5'b00111}, 64'h7);
        chk("R6 mode 3 off", {62'h0, gate_hi[5], gate_lo[5]}, 64'h0);

        // R4 dead band length
        cur_tag = "R4";
        gap_lo_to_hi(0, n); chk("R4 gap lane0 dt=3", 64'(n), 64'd3);
        gap_lo_to_hi(1, n); chk("R4 gap lane1 dt=0", 64'(n), 64'd0);
        gap_lo_to_hi(2, n); chk("R4 gap lane2 dt=5", 64'(n), 64'd5);

        // R5 short low pulse on lane0 (dt=3)
        cur_tag = "R5";
        seen = 0;
        req_a[0] = 0; step(2); req_a[0] = 1;
        for (int k = 0; k < 10; k++) begin
            step(1);
            if (gate_lo[0]) seen = 1;
        end
        chk("R5 suppressed low pulse", {63'h0, seen}, 64'h0);
        chk("R5 high side back", {63'h0, gate_hi[0]}, 64'h1);

        // R6 independent and high-only modes
        cur_tag = "R6";
        req_a[3] = 1; req_b[3] = 1; req_a[4] = 1; req_b[4] = 1;
        step(1);
        chk("R6 mode1 both", {62'h0, gate_hi[3], gate_lo[3]}, 64'h3);
        chk("R6 mode2 hi only", {62'h0, gate_hi[4], gate_lo[4]}, 64'h2);
        req_a[3] = 0; step(1);
        chk("R6 mode1 independent lo", {62'h0, gate_hi[3], gate_lo[3]}, 64'h1);

        // R2 / R3 random patterns
        cur_tag = "R2";
        for (int k = 0; k < 200; k++) begin
            req_a = $urandom; req_b = $urandom;
            step(1 + ($urandom % 6));
        end
        chk("R2 inactive lanes off", {gate_hi[31:7], gate_lo[31:7]}, 64'h0);
        cur_tag = "R3";
        req_a = 32'h1; step(12);
        chk("R3 steady hi lane0", {62'h0, gate_hi[0], gate_lo[0]}, 64'h2);
        req_a = 32'h0; step(12);
        chk("R3 steady lo lane0", {62'h0, gate_hi[0], gate_lo[0]}, 64'h1);

        // R7 clear wins over set
        cur_tag = "R7";
        act_set[1] = 1; act_clr[1] = 1; step(1); act_set = '0; act_clr = '0;
        chk("R7 clear wins", {62'h0, gate_hi[1], gate_lo[1]}, 64'h0);

        // R9 runtime mode write
        cur_tag = "R9";
        wr(0, 0, 3);
        chk("R9 mode3 write lane0", {62'h0, gate_hi[0], gate_lo[0]}, 64'h0);
        wr(0, 0, 0);
        step(10);

        // R8 fault
        cur_tag = "R8";
        req_a = 32'h5A; fault_in = 1; step(1);
        chk("R8 trip", {63'h0, tripped}, 64'h1);
        chk("R8 all off", {gate_hi, gate_lo}, 64'h0);
        fault_clr = 1; step(1); fault_clr = 0;
        chk("R8 clear ignored while fault", {63'h0, tripped}, 64'h1);
        fault_in = 0; step(2);
        chk("R8 still latched", {63'h0, tripped}, 64'h1);
        fault_clr = 1; step(1); fault_clr = 0;
        chk("R8 cleared", {63'h0, tripped}, 64'h0);
        step(12);
        chk("R8 lanes stay inactive", {gate_hi, gate_lo}, 64'h0);
        act_set = 32'h7F; step(1); act_set = '0;
        step(12);
        chk("R8 reactivated lane0 low", {62'h0, gate_hi[0], gate_lo[0]}, 64'h1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule